// File: doc/BRIEF.md
# Finished Store Queue with In-Order Commit

This block sits between the address-translation stages of a load/store pipeline and the committed store queue in front of the data cache. Each store that has a translated address arrives with its access size and a class (integer, floating-point or vector) and is parked in a small in-order queue. The head store commits to architectural state only in a cycle where the reorder tracker says that store is the oldest instruction in flight. A one-cycle commit pulse marks that moment.

Once committed, a store passes through two write-back register stages and then appears on the output toward the committed store queue. That queue may refuse a transfer. While it does, the write-back stages freeze and no further commit happens. Floating-point stores are rate-limited at this point: two of them may not commit closer than three cycles apart. Integer and vector stores commit back to back, one per cycle.

Top module: `fsq_commit_top`

## Requirements
- R1: After reset the queue is empty: `fsq_full`, `commit` and `wb_valid` are all low.
- R2: The queue holds at most three stores, and `fsq_full` is high while three are held. A store presented while `fsq_full` is high is dropped. Only the three stores accepted earlier ever reach the output.
- R3: Stores commit and leave on `wb_*` in the order they were accepted.
- R4: No commit happens while `oldest` is low. A held head store commits in the first cycle where `oldest` is high, provided no other rule blocks it.
- R5: A store that commits in cycle t is presented on `wb_valid`/`wb_*` in cycle t+2.
- R6: Integer (`st_cls`=2'b00) and vector (`st_cls`=2'b10) stores that are queued one behind another commit in consecutive cycles.
- R7: Floating-point stores (`st_cls`=2'b01) commit at least three cycles apart. A floating-point head whose predecessor floating-point store committed in cycle t commits in cycle t+3.
- R8: The floating-point spacing does not delay other classes. An integer store queued behind a floating-point store commits in the cycle after it.
- R9: While `wb_valid` is high and `csq_ready` is low, the output store stays valid and unchanged and `commit` stays low. Once `csq_ready` rises, the held stores drain in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | A translated store is offered this cycle |
| st_addr | input | ADDR_W | Translated store address |
| st_size | input | SIZE_W | Access size code, carried through unchanged |
| st_cls | input | 2 | Store class: 00 integer, 01 floating-point, 10 vector |
| fsq_full | output | 1 | All entries occupied; upstream must hold further stores |
| oldest | input | 1 | The head store is the oldest instruction in flight |
| csq_ready | input | 1 | The committed store queue can take a store this cycle |
| commit | output | 1 | The head store commits to architectural state this cycle |
| wb_valid | output | 1 | A committed store is offered to the committed store queue |
| wb_addr | output | ADDR_W | Address of the offered store |
| wb_size | output | SIZE_W | Size code of the offered store |
| wb_cls | output | 2 | Class of the offered store |

## Verification
The bench builds the block with its default values: three entries, two write-back stages and a floating-point gap of three cycles. A 16-bit address keeps the transfer log readable. With these values the queue can be filled to the point of refusing a fourth store, so the drop rule is reachable. A class mix fits in the queue that shows both the three-cycle floating-point spacing and an integer store slipping in right behind a floating-point one. A downstream refusal also backs up both write-back stages and the queue within a handful of cycles.

// File: rtl/fsq_pkg.sv
`timescale 1ns/1ps
package fsq_pkg;

    typedef enum logic [1:0] {
        CLS_INT = 2'b00,
        CLS_FP  = 2'b01,
        CLS_VEC = 2'b10
    } st_class_e;

    localparam int CLS_W = 2;

endpackage

// File: rtl/fsq_entries.sv
`timescale 1ns/1ps
module fsq_entries #(
    parameter int DEPTH = 3,
    parameter int PAY_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [PAY_W-1:0] push_data,
    input  logic             pop,
    output logic             head_valid,
    output logic [PAY_W-1:0] head_data,
    output logic             full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][PAY_W-1:0] slot;
        logic [PTR_W-1:0]            rd;
        logic [PTR_W-1:0]            wr;
        logic [CNT_W-1:0]            cnt;
    } q_t;

    q_t q_d, q_q;
    logic take, drop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign head_valid = (q_q.cnt != '0);
    assign full       = (q_q.cnt == CNT_W'(DEPTH));
    assign head_data  = q_q.slot[q_q.rd];

    always_comb begin
        q_d  = q_q;
        take = push && !full;
        drop = pop && head_valid;
        if (take) begin
            q_d.slot[q_q.wr] = push_data;
            q_d.wr           = bump(q_q.wr);
        end
        if (drop) begin
            q_d.rd = bump(q_q.rd);
        end
        case ({take, drop})
            2'b10:   q_d.cnt = q_q.cnt + CNT_W'(1);
            2'b01:   q_d.cnt = q_q.cnt - CNT_W'(1);
            default: q_d.cnt = q_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        q_q.cnt <= CNT_W'(DEPTH)); // R2
    AST_FULL_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop) |=> full); // R2
    AST_EMPTY_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (!head_valid && !push) |=> !head_valid); // R3

endmodule

// File: rtl/fsq_fp_throttle.sv
`timescale 1ns/1ps
module fsq_fp_throttle #(
    parameter int GAP = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fp_fire,
    output logic fp_ok
);
    localparam int CW = $clog2(GAP + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } th_t;

    th_t th_d, th_q;

    assign fp_ok = (th_q.cnt == '0);

    always_comb begin
        th_d = th_q;
        if (fp_fire)               th_d.cnt = CW'(GAP - 1);
        else if (th_q.cnt != '0)   th_d.cnt = th_q.cnt - CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) th_q <= '0;
        else        th_q <= th_d;
    end

    // Independent spacing monitor: cycles since the last floating-point commit.
    logic [CW-1:0] since_q;
    logic          seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_q <= '0;
            seen_q  <= 1'b0;
        end else if (fp_fire) begin
            since_q <= '0;
            seen_q  <= 1'b1;
        end else if (since_q != CW'(GAP)) begin
            since_q <= since_q + CW'(1);
        end
    end

    AST_FP_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (fp_fire && seen_q) |-> (since_q >= CW'(GAP - 1))); // R7

endmodule

// File: rtl/fsq_wb_pipe.sv
`timescale 1ns/1ps
module fsq_wb_pipe #(
    parameter int STAGES = 2,
    parameter int PAY_W  = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_fire,
    input  logic [PAY_W-1:0] in_data,
    input  logic             dn_ready,
    output logic             adv,
    output logic             out_valid,
    output logic [PAY_W-1:0] out_data
);
    typedef struct packed {
        logic [STAGES-1:0]            vld;
        logic [STAGES-1:0][PAY_W-1:0] dat;
    } p_t;

    p_t p_d, p_q;

    assign out_valid = p_q.vld[STAGES-1];
    assign out_data  = p_q.dat[STAGES-1];
    assign adv       = !(out_valid && !dn_ready);

    always_comb begin
        p_d = p_q;
        if (adv) begin
            p_d.vld[0] = in_fire;
            p_d.dat[0] = in_data;
            for (int i = 1; i < STAGES; i++) begin
                p_d.vld[i] = p_q.vld[i-1];
                p_d.dat[i] = p_q.dat[i-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !dn_ready) |=> (out_valid && $stable(out_data))); // R9
    AST_NO_FIRE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |-> !in_fire); // R9

endmodule

// File: rtl/fsq_commit_top.sv
`timescale 1ns/1ps
module fsq_commit_top #(
    parameter int ADDR_W    = 16,
    parameter int SIZE_W    = 2,
    parameter int DEPTH     = 3,
    parameter int WB_STAGES = 2,
    parameter int FP_GAP    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_valid,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [SIZE_W-1:0] st_size,
    input  logic [1:0]        st_cls,
    output logic              fsq_full,
    input  logic              oldest,
    input  logic              csq_ready,
    output logic              commit,
    output logic              wb_valid,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [SIZE_W-1:0] wb_size,
    output logic [1:0]        wb_cls
);
    import fsq_pkg::*;

    localparam int PAY_W = CLS_W + SIZE_W + ADDR_W;

    logic             head_valid;
    logic [PAY_W-1:0] head_data;
    logic [PAY_W-1:0] out_data;
    logic             head_fp;
    logic             fp_ok;
    logic             wb_adv;
    logic             fp_fire;

    fsq_entries #(.DEPTH(DEPTH), .PAY_W(PAY_W)) u_entries (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (st_valid),
        .push_data  ({st_cls, st_size, st_addr}),
        .pop        (commit),
        .head_valid (head_valid),
        .head_data  (head_data),
        .full       (fsq_full)
    );

    assign head_fp = (head_data[PAY_W-1 -: CLS_W] == CLS_FP);
    assign commit  = head_valid && oldest && wb_adv && (!head_fp || fp_ok);
    assign fp_fire = commit && head_fp;

    fsq_fp_throttle #(.GAP(FP_GAP)) u_throttle (
        .clk     (clk),
        .rst_n   (rst_n),
        .fp_fire (fp_fire),
        .fp_ok   (fp_ok)
    );

    fsq_wb_pipe #(.STAGES(WB_STAGES), .PAY_W(PAY_W)) u_wb (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_fire   (commit),
        .in_data   (head_data),
        .dn_ready  (csq_ready),
        .adv       (wb_adv),
        .out_valid (wb_valid),
        .out_data  (out_data)
    );

    assign wb_addr = out_data[ADDR_W-1:0];
    assign wb_size = out_data[ADDR_W +: SIZE_W];
    assign wb_cls  = out_data[PAY_W-1 -: CLS_W];

    AST_COMMIT_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> oldest); // R4
    AST_NO_COMMIT_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !csq_ready) |-> !commit); // R9
    AST_FULL_AFTER_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (fsq_full && !commit) |=> fsq_full); // R2

endmodule

// File: tb/fsq_commit_top_bench.sv
`timescale 1ns/1ps
module fsq_commit_top_bench;
    localparam int ADDR_W = 16;
    localparam int SIZE_W = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              st_valid = 1'b0;
    logic [ADDR_W-1:0] st_addr = '0;
    logic [SIZE_W-1:0] st_size = '0;
    logic [1:0]        st_cls = 2'b00;
    logic              oldest = 1'b0;
    logic              csq_ready = 1'b1;
    logic              fsq_full, commit, wb_valid;
    logic [ADDR_W-1:0] wb_addr;
    logic [SIZE_W-1:0] wb_size;
    logic [1:0]        wb_cls;

    fsq_commit_top u_fsq_commit_top (
        .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_addr(st_addr),
        .st_size(st_size), .st_cls(st_cls), .fsq_full(fsq_full),
        .oldest(oldest), .csq_ready(csq_ready), .commit(commit),
        .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_size(wb_size), .wb_cls(wb_cls)
    );

    always #4 clk = ~clk;  // 125 MHz

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit done = 1'b0;

    int ncom = 0;
    int com_cyc [64];
    int nout = 0;
    int out_cyc [64];
    logic [ADDR_W-1:0] out_adr [64];
    logic [1:0]        out_cl  [64];

    always @(posedge clk) cyc <= cyc + 1;

    // Log commits and accepted transfers away from the clock edge.
    always @(negedge clk) begin
        if (rst_n && commit && ncom < 64) begin
            com_cyc[ncom] = cyc;
            ncom++;
        end
        if (rst_n && wb_valid && csq_ready && nout < 64) begin
            out_cyc[nout] = cyc;
            out_adr[nout] = wb_addr;
            out_cl[nout]  = wb_cls;
            nout++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic offer(input logic [ADDR_W-1:0] a, input logic [1:0] c);
        st_valid = 1'b1;
        st_addr  = a;
        st_size  = 2'b10;
        st_cls   = c;
        step(1);
        st_valid = 1'b0;
    endtask

    task automatic t_reset();
        #2;
        chk(fsq_full == 1'b0, "R1 full", int'(fsq_full), 0);
        chk(commit == 1'b0, "R1 commit", int'(commit), 0);
        chk(wb_valid == 1'b0, "R1 wb_valid", int'(wb_valid), 0);
        rst_n = 1'b1;
        step(2);
    endtask

    task automatic t_fill_and_order();
        int c0 = ncom;
        int o0 = nout;
        oldest = 1'b0;
        offer(16'h1000, 2'b00);
        offer(16'h1004, 2'b10);
        offer(16'h1008, 2'b00);
        chk(fsq_full == 1'b1, "R2 full at three", int'(fsq_full), 1);
        offer(16'h100C, 2'b00);   // dropped
        step(3);
        chk(ncom - c0 == 0, "R4 no commit while not oldest", ncom - c0, 0);
        oldest = 1'b1;
        step(10);
        oldest = 1'b0;
        chk(ncom - c0 == 3, "R2 three commits only", ncom - c0, 3);
        chk(nout - o0 == 3, "R2 three transfers only", nout - o0, 3);
        chk(out_adr[o0] == 16'h1000, "R3 order 0", int'(out_adr[o0]), 'h1000);
        chk(out_adr[o0+1] == 16'h1004, "R3 order 1", int'(out_adr[o0+1]), 'h1004);
        chk(out_adr[o0+2] == 16'h1008, "R3 order 2", int'(out_adr[o0+2]), 'h1008);
        chk(com_cyc[c0+1] - com_cyc[c0] == 1, "R6 back to back 0",
            com_cyc[c0+1] - com_cyc[c0], 1);
        chk(com_cyc[c0+2] - com_cyc[c0+1] == 1, "R6 back to back 1",
            com_cyc[c0+2] - com_cyc[c0+1], 1);
        for (int k = 0; k < 3; k++)
            chk(out_cyc[o0+k] - com_cyc[c0+k] == 2, "R5 two-stage latency",
                out_cyc[o0+k] - com_cyc[c0+k], 2);
        chk(fsq_full == 1'b0, "R2 drained", int'(fsq_full), 0);
    endtask

    task automatic t_fp_mix(input logic [1:0] c1, input int gap1, input int gap2,
                            input string tag);
        int c0 = ncom;
        int o0 = nout;
        oldest = 1'b0;
        step(4);
        offer(16'h2000, 2'b01);
        offer(16'h2010, c1);
        offer(16'h2020, 2'b01);
        oldest = 1'b1;
        step(12);
        oldest = 1'b0;
        chk(ncom - c0 == 3, {tag, " commits"}, ncom - c0, 3);
        chk(com_cyc[c0+1] - com_cyc[c0] == gap1, {tag, " first gap"},
            com_cyc[c0+1] - com_cyc[c0], gap1);
        chk(com_cyc[c0+2] - com_cyc[c0+1] == gap2, {tag, " second gap"},
            com_cyc[c0+2] - com_cyc[c0+1], gap2);
        chk(out_cl[o0+1] == c1, {tag, " class carried"}, int'(out_cl[o0+1]), int'(c1));
    endtask

    task automatic t_stall();
        int c0 = ncom;
        int o0 = nout;
        oldest = 1'b0;
        csq_ready = 1'b0;
        step(2);
        offer(16'h3000, 2'b00);
        offer(16'h3004, 2'b00);
        offer(16'h3008, 2'b10);
        oldest = 1'b1;
        step(6);
        chk(ncom - c0 == 2, "R9 commit stops on stall", ncom - c0, 2);
        chk(wb_valid == 1'b1, "R9 output held valid", int'(wb_valid), 1);
        chk(wb_addr == 16'h3000, "R9 output held stable", int'(wb_addr), 'h3000);
        chk(commit == 1'b0, "R9 no commit now", int'(commit), 0);
        csq_ready = 1'b1;
        step(8);
        oldest = 1'b0;
        chk(ncom - c0 == 3, "R9 all committed after release", ncom - c0, 3);
        chk(nout - o0 == 3, "R9 all drained", nout - o0, 3);
        chk(out_adr[o0] == 16'h3000 && out_adr[o0+1] == 16'h3004 &&
            out_adr[o0+2] == 16'h3008, "R9 drain order", int'(out_adr[o0+2]), 'h3008);
    endtask

    initial begin
        t_reset();
        t_fill_and_order();
        t_fp_mix(2'b00, 1, 2, "R8 fp-int-fp");
        t_fp_mix(2'b01, 3, 3, "R7 fp-fp-fp");
        t_stall();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule